// File: doc/BRIEF.md
# I2C Register-Access Slave

This block lets an external I2C master read and write a small internal register file. It watches the two bus lines on the system clock. It recognises start and stop framing and checks the first byte of each transfer against its device address. It pulls the data line low through an open-drain enable, both to acknowledge bytes and to shift register contents back to the master.

A write transfer first loads an 8-bit pointer. Every byte after that is stored in the register the pointer selects. A read transfer sends no pointer: it returns data starting at the register where the pointer was left by earlier traffic. The top pointer bit turns on auto-advance for burst access. The low address bit comes from a strap pin, so two devices can share one bus. A second strap is captured once after reset and decides whether the port responds at all.

Top module: `i2c_regport`

## Requirements
- R1: A falling edge of SDA while SCL is high (start) begins address reception from any state. A rising edge of SDA while SCL is high (stop) returns the port to idle with SDA released. Each such event leaves `sda_oe` low on the next clock.
- R2: The first byte after a start holds the 7-bit device address, most significant bit first, followed by the R/W bit (1 = read). The address is 0b001000 followed by the level of `addr_lsb_strap`, which gives write bytes 0x20 or 0x22. On a match the port pulls SDA low during the ninth clock. On a mismatch it does not acknowledge and ignores all traffic until the next start.
- R3: In a write, the byte after the address loads the pointer and is acknowledged. Each later byte is acknowledged and stored in register `ptr[REG_AW-1:0]`.
- R4: When pointer bit 7 is 1, the low REG_AW pointer bits advance by one, modulo 2^REG_AW, after each data byte written or read; the other bits are kept. When bit 7 is 0 the pointer holds.
- R5: In a read, the port shifts out the register at the current pointer, most significant bit first. It changes SDA only while SCL is low.
- R6: A read continues with the next byte while the master acknowledges. After a master non-acknowledge the port releases SDA and stays silent until the next start.
- R7: `mode_strap` is sampled on the first clock after `rst_n` deasserts. Low enables the port (`i2c_enabled`=1). High disables it, and SDA is never driven. Later changes of the strap have no effect until the next reset.
- R8: After reset all registers read 0x00, the pointer is 0x00 and SDA is released.
- R9: A repeated start after a pointer write restarts address reception. A read then returns data from the pointer just loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| addr_lsb_strap | input | 1 | Device address bit 0 |
| mode_strap | input | 1 | Captured after reset; low enables the port |
| i2c_enabled | output | 1 | Latched port-enable state |

## Verification
A burst write starting at pointer 0x8F must land in the last register and then register 0. A design that saturates, or that carries into the upper pointer bits, would corrupt another register or return stale data on readback. A read after a repeated start must use the pointer from the aborted write. A design that clears the pointer on a start would return register 0 instead. Addresses with a wrong strap bit or wrong upper bits must get no acknowledge and must not store their trailing bytes. After a master non-acknowledge the bench clocks one more byte and expects 0xFF, which catches a slave that keeps driving. With the mode strap high the port must never drive SDA, even after the strap drops later.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_RACK
   } port_st_e;

   typedef enum logic [1:0] {
      PH_ADDR,
      PH_PTR,
      PH_DATA
   } byte_ph_e;

   localparam logic [5:0] DEV_ADDR_HI = 6'b001000;
   localparam int         BYTE_W      = 8;
endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_regport_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_ff, sda_ff;
   logic              scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_q  <= scl_ff[STAGES-1];
         sda_q  <= sda_ff[STAGES-1];
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_regport_regfile.sv
module i2c_regport_regfile #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int NREG = 1 << AW;

   if (AW < 1 || AW > 7) begin : g_bad_aw
      $error("i2c_regport_regfile: AW must be 1..7");
   end

   logic [DW-1:0] word [NREG];

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [DW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (we && waddr == AW'(g))
            q <= wdata;
      end
      assign word[g] = q;
   end

   assign rdata = word[raddr];
endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
   import i2c_regport_pkg::*;
#(
   parameter int REG_AW      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe,
   input  logic addr_lsb_strap,
   input  logic mode_strap,
   output logic i2c_enabled
);
   if (REG_AW < 1 || REG_AW > 7) begin : g_bad_reg_aw
      $error("i2c_regport: REG_AW must be 1..7 (pointer bit 7 is the advance flag)");
   end

   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2c_regport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   port_st_e          st;
   byte_ph_e          ph;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] sh, tx, ptr, rd_data;
   logic              rw, mack, oe, en_q, armed;
   logic              wr_en;

   function automatic logic [BYTE_W-1:0] ptr_adv(input logic [BYTE_W-1:0] p);
      logic [BYTE_W-1:0] r;
      r = p;
      if (p[BYTE_W-1])
         r[REG_AW-1:0] = p[REG_AW-1:0] + REG_AW'(1);
      return r;
   endfunction

   wire dev_match = (sh[7:2] == DEV_ADDR_HI) && (sh[1] == addr_lsb_strap);

   assign wr_en = en_q && (st == ST_RX) && scl_fall && (bitcnt == LAST_RX)
                  && (ph == PH_DATA) && !start_det && !stop_det;

   i2c_regport_regfile #(.AW(REG_AW), .DW(BYTE_W)) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .waddr (ptr[REG_AW-1:0]),
      .wdata (sh),
      .raddr (ptr[REG_AW-1:0]),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         ph     <= PH_ADDR;
         bitcnt <= '0;
         sh     <= '0;
         tx     <= '0;
         ptr    <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         oe     <= 1'b0;
         en_q   <= 1'b0;
         armed  <= 1'b0;
      end else begin
         if (!armed) begin
            armed <= 1'b1;
            en_q  <= ~mode_strap;
         end
         if (!en_q) begin
            st <= ST_IDLE;
            oe <= 1'b0;
         end else if (start_det) begin
            st     <= ST_RX;
            ph     <= PH_ADDR;
            bitcnt <= '0;
            oe     <= 1'b0;
         end else if (stop_det) begin
            st <= ST_IDLE;
            oe <= 1'b0;
         end else begin
            unique case (st)
               ST_RX: begin
                  if (scl_rise && bitcnt != LAST_RX) begin
                     sh     <= {sh[BYTE_W-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == LAST_RX) begin
                     unique case (ph)
                        PH_ADDR: begin
                           if (dev_match) begin
                              rw <= sh[0];
                              oe <= 1'b1;
                              st <= ST_ACK;
                           end else begin
                              st <= ST_IDLE;
                           end
                        end
                        PH_PTR: begin
                           ptr <= sh;
                           oe  <= 1'b1;
                           st  <= ST_ACK;
                        end
                        default: begin
                           ptr <= ptr_adv(ptr);
                           oe  <= 1'b1;
                           st  <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (ph == PH_ADDR && rw) begin
                        st  <= ST_TX;
                        tx  <= rd_data;
                        oe  <= ~rd_data[BYTE_W-1];
                        ptr <= ptr_adv(ptr);
                     end else begin
                        st <= ST_RX;
                        oe <= 1'b0;
                        ph <= (ph == PH_ADDR) ? PH_PTR : PH_DATA;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_TX) begin
                        st <= ST_RACK;
                        oe <= 1'b0;
                     end else begin
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        oe     <= ~tx[BYTE_W-2];
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        st     <= ST_TX;
                        bitcnt <= '0;
                        tx     <= rd_data;
                        oe     <= ~rd_data[BYTE_W-1];
                        ptr    <= ptr_adv(ptr);
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe      = oe;
   assign i2c_enabled = en_q;
endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic stop_det,
   input logic sda_oe,
   input logic i2c_enabled
);
   logic [1:0] age;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         age <= '0;
      else if (age != 2'd2)
         age <= age + 2'd1;
   end

   // R7: a disabled port never drives the bus
   a_r7_silent_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !i2c_enabled |-> !sda_oe);

   // R7: the captured strap does not move after its sampling clock
   a_r7_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd2) |-> $stable(i2c_enabled));

   // R1: stop releases the line
   a_r1_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R1: start releases the line
   a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R5: the slave only begins pulling low while SCL is low
   a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_regport i2c_regport_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_s       (scl_s),
   .start_det   (start_det),
   .stop_det    (stop_det),
   .sda_oe      (sda_oe),
   .i2c_enabled (i2c_enabled)
);

// File: tb/i2c_regport_bench.sv
module i2c_regport_bench;
   localparam int AW = 4;
   localparam int NR = 16;
   localparam int Q  = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic addr_lsb_strap = 1'b0, mode_strap = 1'b0;
   logic sda_oe, i2c_enabled;
   wire  sda_bus = sda_m & ~sda_oe;

   int checks = 0, fails = 0;
   logic [7:0] mreg [NR];
   logic [7:0] mptr;
   logic [7:0] wbuf [4];
   bit watch_oe = 0, oe_seen = 0;

   always #5 clk = ~clk;

   i2c_regport u_i2c_regport (
      .clk            (clk),
      .rst_n          (rst_n),
      .scl_i          (scl_m),
      .sda_i          (sda_bus),
      .sda_oe         (sda_oe),
      .addr_lsb_strap (addr_lsb_strap),
      .mode_strap     (mode_strap),
      .i2c_enabled    (i2c_enabled)
   );

   always @(negedge clk) if (watch_oe && sda_oe) oe_seen = 1;

   function automatic logic [7:0] adv(input logic [7:0] p);
      logic [7:0] r = p;
      if (p[7]) r[AW-1:0] = p[AW-1:0] + 1'b1;
      return r;
   endfunction

   function automatic logic [7:0] dev_byte(input bit lsb, input bit rd);
      return {6'b001000, lsb, rd};
   endfunction

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic i2c_start();
      sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic i2c_stop();
      sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
      end
      sda_m = 1; tick(Q); scl_m = 1; tick(Q);
      acked = !sda_bus;
      tick(Q); scl_m = 0; tick(Q);
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] d);
      sda_m = 1;
      for (int i = 0; i < 8; i++) begin
         tick(Q); scl_m = 1; tick(Q); d = {d[6:0], sda_bus}; tick(Q); scl_m = 0; tick(Q);
      end
      sda_m = give_ack ? 1'b0 : 1'b1;
      tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
      sda_m = 1;
   endtask

   task automatic do_write(input logic [7:0] p, input int n);
      bit a;
      i2c_start();
      send_byte(dev_byte(addr_lsb_strap, 0), a);
      chk(a, "R2 address ack", a, 1);
      send_byte(p, a);
      chk(a, "R3 pointer ack", a, 1);
      mptr = p;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], a);
         chk(a, "R3 data ack", a, 1);
         mreg[mptr[AW-1:0]] = wbuf[i];
         mptr = adv(mptr);
      end
      i2c_stop();
   endtask

   task automatic do_read(input int n, input string tag);
      bit a;
      logic [7:0] d;
      i2c_start();
      send_byte(dev_byte(addr_lsb_strap, 1), a);
      chk(a, "R2 read address ack", a, 1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n - 1, d);
         chk(d == mreg[mptr[AW-1:0]], tag, d, mreg[mptr[AW-1:0]]);
         mptr = adv(mptr);
      end
      i2c_stop();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      bit a;
      logic [7:0] d;
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      for (int i = 0; i < NR; i++) mreg[i] = 8'h00;
      mptr = 8'h00;

      tick(4); rst_n = 1; tick(4);
      chk(sda_oe == 0, "R8 SDA released after reset", sda_oe, 0);
      chk(i2c_enabled == 1, "R7 strap low enables", i2c_enabled, 1);

      // R8: reset pointer 0 (no advance) then whole file zero via advancing pointer
      do_read(2, "R8 reset pointer and value");
      do_write(8'h80, 0);
      do_read(NR + 1, "R8 reset contents with R4 wrap");

      // R4: pointer without advance flag holds
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      do_write(8'h03, 3);
      do_write(8'h03, 0);
      do_read(2, "R4 hold pointer read");

      // R4: wrap from top register to register 0
      wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
      do_write(8'h8F, 2);

      // R9: repeated start after pointer write, then read
      i2c_start();
      send_byte(dev_byte(0, 0), a); chk(a, "R9 address ack", a, 1);
      send_byte(8'h8F, a);          chk(a, "R9 pointer ack", a, 1);
      mptr = 8'h8F;
      i2c_start();
      send_byte(dev_byte(0, 1), a); chk(a, "R9 read ack", a, 1);
      recv_byte(1, d); chk(d == 8'h5A, "R9 first byte after restart", d, 8'h5A);
      recv_byte(0, d); chk(d == 8'hA5, "R4 wrapped byte", d, 8'hA5);
      i2c_stop();
      mptr = 8'h81;

      // R2: wrong strap bit and wrong upper bits are ignored with trailing bytes
      i2c_start();
      send_byte(dev_byte(1, 0), a); chk(!a, "R2 wrong lsb nack", a, 0);
      send_byte(8'h8F, a);          chk(!a, "R2 ignored byte nack", a, 0);
      send_byte(8'hEE, a);          chk(!a, "R2 ignored data nack", a, 0);
      i2c_stop();
      i2c_start();
      send_byte(8'h60, a); chk(!a, "R2 wrong upper bits nack", a, 0);
      i2c_stop();
      do_read(1, "R2 pointer kept after mismatch");
      do_write(8'h0F, 0);
      do_read(1, "R2 register untouched by mismatch");

      // R6: master NACK ends the read; slave silent afterward
      do_write(8'h80, 0);
      i2c_start();
      send_byte(dev_byte(0, 1), a); chk(a, "R6 read ack", a, 1);
      recv_byte(1, d); chk(d == mreg[0], "R6 byte 0", d, mreg[0]);
      recv_byte(0, d); chk(d == mreg[1], "R6 byte 1", d, mreg[1]);
      recv_byte(0, d); chk(d == 8'hFF, "R6 released after nack", d, 8'hFF);
      i2c_stop();
      mptr = 8'h82;

      // R2: strap bit 1 moves the address
      addr_lsb_strap = 1;
      i2c_start();
      send_byte(dev_byte(0, 0), a); chk(!a, "R2 old address nack", a, 0);
      i2c_stop();
      wbuf[0] = 8'h3C;
      do_write(8'h07, 1);
      do_read(1, "R2 strap one access");
      addr_lsb_strap = 0;

      // random bursts against the model (R3 R4 R5)
      for (int it = 0; it < 30; it++) begin
         int n;
         logic [7:0] p;
         n = int'($urandom_range(1, 3));
         p = 8'($urandom());
         if ($urandom_range(0, 1) == 1) begin
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom());
            do_write(p, n);
            do_read(n, "R5 readback after random write");
         end else begin
            do_write(p, 0);
            do_read(n, "R3 random read");
         end
      end

      // R7: strap high disables; later change ignored
      mode_strap = 1; rst_n = 0; tick(4); rst_n = 1; tick(4);
      mode_strap = 0; watch_oe = 1;
      chk(i2c_enabled == 0, "R7 strap high disables", i2c_enabled, 0);
      i2c_start();
      send_byte(dev_byte(0, 0), a); chk(!a, "R7 disabled nack", a, 0);
      i2c_stop();
      tick(20);
      chk(i2c_enabled == 0, "R7 later strap change ignored", i2c_enabled, 0);
      i2c_start();
      send_byte(dev_byte(0, 1), a); chk(!a, "R7 still disabled", a, 0);
      i2c_stop();
      chk(!oe_seen, "R7 never drove SDA", oe_seen, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule